// File: doc/BRIEF.md
# Child Task Launch Controller

This block starts one child compute task on behalf of a parent and follows it until it completes. On the parent side it sees a global start and a global done; on the child side it drives a start request and watches the child's ready and done. A per-child finished flag goes back to the parent, which combines it with the flags of sibling children and then raises the global done that lets every child re-arm.

The block has no reset of its own in the controller logic. The active-low reset, the global start, the global done, the child's argument word and the finished flag each pass through `DEPTH` register stages. This lets the controller sit far from the parent control on a large die. A `DEPTH` of 0 uses every signal directly. While `rst_n` is low, every stage clears at once. The controller then sees only the delayed copy of the reset.

The launch machine has four states:

| State | Encoding | Exits |
|-------|----------|-------|
| IDLE | 00 | To LAUNCH when the delayed start is high. |
| LAUNCH | 01 | Needs ready. With done also high it goes to FIN, without done to RUN. |
| RUN | 11 | To FIN on done. |
| FIN | 10 | To IDLE on the delayed global done. |

With `AUTORUN` set there is no launch machine. Once the delayed global start is seen, the child's start is latched high and stays high.

Top module: `child_launch_ctrl`

## Requirements
- R1: While `rst_n` is low, every pipeline stage reads 0 and so `child_rst_n` and `finished` are 0. While the delayed reset is low, the next clock edge forces the state to IDLE (encoding 00) and `child_start` is low.
- R2: In IDLE the controller moves to LAUNCH (01) at the edge where the last stage of the delayed global start is high. Otherwise it stays in IDLE.
- R3: In LAUNCH with `child_ready` high, the controller moves to FIN (10) if `child_done` is high in the same cycle and to RUN (11) otherwise. With `child_ready` low it stays in LAUNCH.
- R4: In RUN the controller moves to FIN on a cycle with `child_done` high and otherwise stays in RUN.
- R5: In FIN the controller returns to IDLE only when the last stage of the delayed global done is high, so no relaunch occurs before the global done has propagated.
- R6: `child_start` is high exactly in the cycles where the state is LAUNCH, driven without a register from the state.
- R7: `finished` equals "state is FIN" delayed by `DEPTH` clock edges.
- R8: `child_rst_n`, the delayed start, the delayed done and `arg_out` lag their inputs by exactly `DEPTH` edges. With `DEPTH` = 0 they equal their inputs.
- R9: With `AUTORUN` = 1, `child_start` is cleared while the delayed reset is low. It is set at the first edge with the delayed global start high and then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all stages and the state |
| rst_n | input | 1 | Active-low reset; clears the pipeline stages at once |
| glb_start | input | 1 | Parent's global start |
| glb_done | input | 1 | Parent's global done, which re-arms the controller |
| arg_in | input | ARG_W | Scalar or address argument for the child |
| child_ready | input | 1 | Child accepted the start |
| child_done | input | 1 | Child completed its work |
| child_start | output | 1 | Start request to the child |
| child_rst_n | output | 1 | Delayed reset forwarded to the child |
| arg_out | output | ARG_W | Argument after the last pipeline stage |
| finished | output | 1 | Delayed "child finished" flag for the parent |

## Verification
On every cycle, assertions check the following local moves of the launch machine:
- IDLE holds without a start.
- LAUNCH holds without ready, and ready with done lands in FIN.
- RUN leaves on done.
- FIN holds until the delayed global done.
- Reset forces IDLE.
- The autorun start latch stays high.

Only the bench scenarios can show the end-to-end latencies through the pipeline and the relation of `finished` to the state. The same holds for the one-cycle start pulse when ready and done arrive together, and for the absence of a relaunch until the global done has propagated. The bench checks these against a cycle model under both random and directed traffic.

// File: rtl/launch_pkg.sv
package launch_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_LAUNCH = 2'b01,
        ST_RUN    = 2'b11,
        ST_FIN    = 2'b10
    } launch_state_e;
endpackage

// File: rtl/stage_pipe.sv
module stage_pipe #(
    parameter int W     = 1,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (DEPTH == 0) begin : g_direct
            assign q = d;
        end else begin : g_regs
            logic [W-1:0] stg [DEPTH];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
                end else begin
                    stg[0] <= d;
                    for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
                end
            end
            assign q = stg[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/launch_fsm.sv
module launch_fsm
    import launch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rst_q,
    input  logic start_q,
    input  logic done_q,
    input  logic ready,
    input  logic done,
    output logic start,
    output logic is_fin
);
    launch_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_q) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_q) state_d = ST_LAUNCH;
            ST_LAUNCH: if (ready)   state_d = done ? ST_FIN : ST_RUN;
            ST_RUN:    if (done)    state_d = ST_FIN;
            ST_FIN:    if (done_q)  state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        start  = (state_q == ST_LAUNCH);
        is_fin = (state_q == ST_FIN);
    end

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_q |=> state_q == ST_IDLE);
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n || !rst_q)
        (state_q == ST_IDLE && !start_q) |=> state_q == ST_IDLE);
    p_launch_wait_r3: assert property (@(posedge clk) disable iff (!rst_n || !rst_q)
        (state_q == ST_LAUNCH && !ready) |=> start);
    p_launch_same_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n || !rst_q)
        (start && ready && done) |=> is_fin);
    p_run_exit_r4: assert property (@(posedge clk) disable iff (!rst_n || !rst_q)
        (state_q == ST_RUN && done) |=> is_fin);
    p_fin_hold_r5: assert property (@(posedge clk) disable iff (!rst_n || !rst_q)
        (is_fin && !done_q) |=> is_fin);
endmodule

// File: rtl/autorun_latch.sv
module autorun_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_q,
    input  logic start_q,
    output logic start
);
    always_ff @(posedge clk) begin
        if (!rst_q)       start <= 1'b0;
        else if (start_q) start <= 1'b1;
    end

    p_autorun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n || !rst_q)
        start |=> start);
    p_autorun_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_q |=> !start);
endmodule

// File: rtl/child_launch_ctrl.sv
module child_launch_ctrl #(
    parameter int DEPTH   = 2,
    parameter int ARG_W   = 64,
    parameter bit AUTORUN = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             glb_start,
    input  logic             glb_done,
    input  logic [ARG_W-1:0] arg_in,
    input  logic             child_ready,
    input  logic             child_done,
    output logic             child_start,
    output logic             child_rst_n,
    output logic [ARG_W-1:0] arg_out,
    output logic             finished
);
    logic rst_q, start_q, done_q, fin_raw;

    stage_pipe #(.W(1), .DEPTH(DEPTH)) u_rst_pipe (
        .clk(clk), .rst_n(rst_n), .d(rst_n), .q(rst_q));
    stage_pipe #(.W(1), .DEPTH(DEPTH)) u_start_pipe (
        .clk(clk), .rst_n(rst_n), .d(glb_start), .q(start_q));
    stage_pipe #(.W(1), .DEPTH(DEPTH)) u_done_pipe (
        .clk(clk), .rst_n(rst_n), .d(glb_done), .q(done_q));
    stage_pipe #(.W(ARG_W), .DEPTH(DEPTH)) u_arg_pipe (
        .clk(clk), .rst_n(rst_n), .d(arg_in), .q(arg_out));

    generate
        if (AUTORUN) begin : g_autorun
            autorun_latch u_latch (
                .clk(clk), .rst_n(rst_n), .rst_q(rst_q),
                .start_q(start_q), .start(child_start));
            assign fin_raw = 1'b0;
        end else begin : g_fsm
            launch_fsm u_fsm (
                .clk(clk), .rst_n(rst_n), .rst_q(rst_q),
                .start_q(start_q), .done_q(done_q),
                .ready(child_ready), .done(child_done),
                .start(child_start), .is_fin(fin_raw));
        end
    endgenerate

    stage_pipe #(.W(1), .DEPTH(DEPTH)) u_fin_pipe (
        .clk(clk), .rst_n(rst_n), .d(fin_raw), .q(finished));

    assign child_rst_n = rst_q;
endmodule

// File: tb/tb_child_launch_ctrl.sv
module tb_child_launch_ctrl;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic glb_start = 1'b0, glb_done = 1'b0, child_ready = 1'b0, child_done = 1'b0;
    logic [63:0] arg_in = '0;
    logic child_start, child_rst_n, finished, ar_start, ar_rst_n, ar_fin;
    logic [63:0] arg_out, ar_arg;

    int total = 0, bad = 0;
    bit finished_run = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    child_launch_ctrl #(.DEPTH(2), .ARG_W(64), .AUTORUN(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .glb_start(glb_start), .glb_done(glb_done),
        .arg_in(arg_in), .child_ready(child_ready), .child_done(child_done),
        .child_start(child_start), .child_rst_n(child_rst_n),
        .arg_out(arg_out), .finished(finished));

    child_launch_ctrl #(.DEPTH(1), .ARG_W(64), .AUTORUN(1'b1)) dut_ar (
        .clk(clk), .rst_n(rst_n), .glb_start(glb_start), .glb_done(glb_done),
        .arg_in(arg_in), .child_ready(child_ready), .child_done(child_done),
        .child_start(ar_start), .child_rst_n(ar_rst_n),
        .arg_out(ar_arg), .finished(ar_fin));

    // cycle model (depth 2 main, depth 1 autorun)
    logic [1:0]  m_st = 2'b00;
    logic [1:0]  m_rs = '0, m_gs = '0, m_gd = '0, m_fn = '0;
    logic [63:0] m_ar0 = '0, m_ar1 = '0;
    logic        a_rs = 0, a_gs = 0, a_st = 0;

    function automatic logic [1:0] next_state(logic [1:0] s, logic rl, logic gs,
                                              logic gd, logic rdy, logic dn);
        if (!rl) return 2'b00;
        case (s)
            2'b00: return gs ? 2'b01 : 2'b00;
            2'b01: return rdy ? (dn ? 2'b10 : 2'b11) : 2'b01;
            2'b11: return dn ? 2'b10 : 2'b11;
            default: return gd ? 2'b00 : 2'b10;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic gs, input logic gd,
                        input logic rdy, input logic dn, input logic [63:0] a);
        logic [1:0] ns;
        rst_n = r; glb_start = gs; glb_done = gd;
        child_ready = rdy; child_done = dn; arg_in = a;
        if (!r) begin
            m_rs = '0; m_gs = '0; m_gd = '0; m_fn = '0; m_ar0 = '0; m_ar1 = '0;
            m_st = 2'b00; a_rs = 0; a_gs = 0; a_st = 0;
        end else begin
            ns = next_state(m_st, m_rs[1], m_gs[1], m_gd[1], rdy, dn);
            m_fn = {m_fn[0], m_st == 2'b10};
            m_rs = {m_rs[0], 1'b1};
            m_gs = {m_gs[0], gs};
            m_gd = {m_gd[0], gd};
            m_ar1 = m_ar0; m_ar0 = a;
            m_st = ns;
            if (!a_rs) a_st = 0; else if (a_gs) a_st = 1;
            a_rs = 1; a_gs = gs;
        end
        @(negedge clk);
        check(child_start === (m_st == 2'b01), "R6", "child_start", {63'd0, child_start}, {63'd0, m_st == 2'b01});
        check(finished === m_fn[1], "R7", "finished", {63'd0, finished}, {63'd0, m_fn[1]});
        check(child_rst_n === m_rs[1], "R1", "child_rst_n", {63'd0, child_rst_n}, {63'd0, m_rs[1]});
        check(arg_out === m_ar1, "R8", "arg_out", arg_out, m_ar1);
        check(ar_start === a_st, "R9", "autorun start", {63'd0, ar_start}, {63'd0, a_st});
        check(ar_arg === m_ar0, "R8", "autorun arg depth1", ar_arg, m_ar0);
    endtask

    initial begin : main
        int pulses;
        bit seen;
        void'($urandom(32'd1234));
        @(negedge clk);
        repeat (4) step(0, 0, 0, 0, 0, 64'h0);
        check(child_start === 1'b0 && finished === 1'b0 && child_rst_n === 1'b0,
              "R1", "reset outputs", {61'd0, child_start, finished, child_rst_n}, 64'd0);
        repeat (3) step(1, 0, 0, 0, 0, 64'h0);
        check(child_rst_n === 1'b1, "R8", "reset released after depth", {63'd0, child_rst_n}, 64'd1);

        // R3: ready and done together with start -> straight to FIN
        step(1, 1, 0, 1, 1, 64'hA5A5_0000_1111_2222);
        pulses = 0;
        for (int i = 0; i < 6; i++) begin
            step(1, 0, 0, 1, 1, 64'(i));
            if (child_start) pulses++;
        end
        check(pulses == 1, "R3", "one-cycle start pulse", 64'(pulses), 64'd1);
        check(finished === 1'b1, "R3", "finished after same-cycle ready/done", {63'd0, finished}, 64'd1);

        // R5: no relaunch while global done has not propagated
        seen = 0;
        for (int i = 0; i < 10; i++) begin
            step(1, 1, 0, 1, 1, 64'h0);
            if (child_start) seen = 1;
        end
        check(!seen, "R5", "no relaunch before global done", {63'd0, seen}, 64'd0);
        step(1, 1, 1, 0, 0, 64'h0);
        seen = 0;
        for (int i = 0; i < 8; i++) begin
            step(1, 1, 0, 0, 0, 64'h0);
            if (child_start) seen = 1;
        end
        check(seen, "R2", "relaunch after global done", {63'd0, seen}, 64'd1);

        // R4: ready without done -> RUN, waits for done
        repeat (3) step(1, 0, 0, 1, 0, 64'h0);
        repeat (5) step(1, 0, 0, 0, 0, 64'h0);
        check(finished === 1'b0 && child_start === 1'b0, "R4", "running, not finished",
              {62'd0, finished, child_start}, 64'd0);
        step(1, 0, 0, 0, 1, 64'h0);
        repeat (3) step(1, 0, 0, 0, 0, 64'h0);
        check(finished === 1'b1, "R4", "finished after done", {63'd0, finished}, 64'd1);
        repeat (3) step(1, 0, 1, 0, 0, 64'h0);

        // random traffic
        for (int i = 0; i < 2000; i++) begin
            logic r;
            r = ($urandom_range(0, 99) != 0);
            step(r, $urandom_range(0, 3) == 0, $urandom_range(0, 5) == 0,
                 $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0,
                 {$urandom, $urandom});
        end
        finished_run = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished_run) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule